// File: doc/BRIEF.md
# Polynomial Difference-Table Evaluator

This block produces the successive values of a second-order polynomial using only repeated addition over a difference table. The caller writes a starting function value, a starting first difference and a constant second difference in one load pulse. Each accepted step request then advances the table by one position and presents the new function value, the new first difference and the position index, with a valid flag.

There is no multiplier. A single adder is time-shared between the two table columns. A step takes two adder cycles: the first difference is refreshed first, then the function value is refreshed using the new first difference.

The result is held under a ready/valid handshake until it is taken. Any carry out of the register width raises a sticky overflow flag.

For example, loading 41, 0 and 2 yields the sequence of n^2 + n + 41.

Top module: `diff_eval_top`

## Requirements
- R1: After reset, out_valid_o, overflow_o and busy_o are 0 and out_index_o is 0.
- R2: A load pulse writes the three table registers and sets the index to 0. It also clears out_valid_o and overflow_o. In the next cycle, out_value_o and out_diff_o show the loaded function value and first difference. A load takes priority over a step in progress and aborts it.
- R3: Each completed step increments out_index_o by one. It sets out_value_o to the previous function value plus the new first difference, modulo 2^W.
- R4: Each step sets the first difference to its previous value plus the second difference. The second difference never changes except by a load. With the loading 41/0/2, the values after steps 1 to 4 are 43, 47, 53, 61 and the differences are 2, 4, 6, 8.
- R5: A step request is sampled on a clock edge while the block is idle. busy_o is then high for the next two cycles. out_valid_o is high after the second edge following the sampling edge.
- R6: A step request while busy_o is high is ignored.
- R7: While out_valid_o is high and out_ready_i is low, out_value_o and out_index_o hold and a step request is ignored. The result is taken on an edge where both are high.
- R8: overflow_o sets when either addition of a step carries out of W bits.
- R9: overflow_o stays set until a load (or reset) clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load pulse for the table registers |
| f_init_i | input | W | Starting function value |
| d1_init_i | input | W | Starting first difference |
| d2_init_i | input | W | Constant second difference |
| step_i | input | 1 | Step request |
| out_ready_i | input | 1 | Consumer accepts the presented result |
| out_valid_o | output | 1 | A new result is presented |
| out_value_o | output | W | Current function value |
| out_diff_o | output | W | Current first difference |
| out_index_o | output | IW | Current position index |
| busy_o | output | 1 | A step is in progress |
| overflow_o | output | 1 | Sticky carry-out flag |

## Verification
The bench builds the block with W = 32 and IW = 16. The 32-bit width lets it place the function value or the first difference a few units below 2^32. That way each of the two adder phases can be driven to a carry within one or two steps. The 16-bit index never wraps in the short runs, so every expected index is a plain count from the last load.

// File: rtl/diff_eval_pkg.sv
`timescale 1ns/1ps
package diff_eval_pkg;

    // Sequencer phases: idle, first-difference update, function update
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIFF = 2'd1,
        ST_FUNC = 2'd2
    } phase_e;

    // A step may start only when idle and no result is stuck waiting
    function automatic logic step_allowed(input logic req,
                                          input logic busy,
                                          input logic pend,
                                          input logic rdy);
        return req && !busy && (!pend || rdy);
    endfunction

endpackage

// File: rtl/diff_eval_adder.sv
`timescale 1ns/1ps
module diff_eval_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o
);
    localparam int SW = W + 1;

    logic [SW-1:0] full;

    always_comb begin
        full    = {1'b0, a_i} + {1'b0, b_i};
        sum_o   = full[W-1:0];
        carry_o = full[SW-1];
    end
endmodule

// File: rtl/diff_eval_ctrl.sv
`timescale 1ns/1ps
module diff_eval_ctrl
    import diff_eval_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_i,
    input  logic   step_i,
    input  logic   out_ready_i,
    output phase_e phase_o,
    output logic   busy_o,
    output logic   valid_o
);
    phase_e phase_q;
    logic   valid_q;
    logic   go;

    always_comb begin
        busy_o  = (phase_q != ST_IDLE);
        go      = step_allowed(step_i, busy_o, valid_q, out_ready_i);
        phase_o = phase_q;
        valid_o = valid_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            valid_q <= 1'b0;
        end else if (load_i) begin
            phase_q <= ST_IDLE;
            valid_q <= 1'b0;
        end else begin
            case (phase_q)
                ST_IDLE: begin
                    if (valid_q && out_ready_i) valid_q <= 1'b0;
                    if (go) phase_q <= ST_DIFF;
                end
                ST_DIFF: phase_q <= ST_FUNC;
                ST_FUNC: begin
                    phase_q <= ST_IDLE;
                    valid_q <= 1'b1;
                end
                default: phase_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/diff_eval_regs.sv
`timescale 1ns/1ps
module diff_eval_regs #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [W-1:0]  f_init_i,
    input  logic [W-1:0]  d1_init_i,
    input  logic [W-1:0]  d2_init_i,
    input  logic          wr_d1_i,
    input  logic          wr_f_i,
    input  logic [W-1:0]  sum_i,
    input  logic          carry_i,
    output logic [W-1:0]  f_o,
    output logic [W-1:0]  d1_o,
    output logic [W-1:0]  d2_o,
    output logic [IW-1:0] idx_o,
    output logic          ovf_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            f_o   <= '0;
            d1_o  <= '0;
            d2_o  <= '0;
            idx_o <= '0;
            ovf_o <= 1'b0;
        end else if (load_i) begin
            f_o   <= f_init_i;
            d1_o  <= d1_init_i;
            d2_o  <= d2_init_i;
            idx_o <= '0;
            ovf_o <= 1'b0;
        end else begin
            if (wr_d1_i) d1_o <= sum_i;
            if (wr_f_i) begin
                f_o   <= sum_i;
                idx_o <= idx_o + IW'(1);
            end
            if ((wr_d1_i || wr_f_i) && carry_i) ovf_o <= 1'b1;
        end
    end
endmodule

// File: rtl/diff_eval_top.sv
`timescale 1ns/1ps
module diff_eval_top
    import diff_eval_pkg::*;
#(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [W-1:0]  f_init_i,
    input  logic [W-1:0]  d1_init_i,
    input  logic [W-1:0]  d2_init_i,
    input  logic          step_i,
    input  logic          out_ready_i,
    output logic          out_valid_o,
    output logic [W-1:0]  out_value_o,
    output logic [W-1:0]  out_diff_o,
    output logic [IW-1:0] out_index_o,
    output logic          busy_o,
    output logic          overflow_o
);
    phase_e        phase;
    logic          wr_d1, wr_f;
    logic [W-1:0]  f_q, d1_q, d2_q;
    logic [W-1:0]  op_a, op_b, sum;
    logic          carry;

    diff_eval_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .step_i      (step_i),
        .out_ready_i (out_ready_i),
        .phase_o     (phase),
        .busy_o      (busy_o),
        .valid_o     (out_valid_o)
    );

    // Shared adder: operand pair chosen by the current phase
    always_comb begin
        wr_d1 = (phase == ST_DIFF);
        wr_f  = (phase == ST_FUNC);
        if (wr_f) begin
            op_a = f_q;
            op_b = d1_q;
        end else begin
            op_a = d1_q;
            op_b = d2_q;
        end
    end

    diff_eval_adder #(.W(W)) u_add (
        .a_i     (op_a),
        .b_i     (op_b),
        .sum_o   (sum),
        .carry_o (carry)
    );

    diff_eval_regs #(.W(W), .IW(IW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .f_init_i  (f_init_i),
        .d1_init_i (d1_init_i),
        .d2_init_i (d2_init_i),
        .wr_d1_i   (wr_d1),
        .wr_f_i    (wr_f),
        .sum_i     (sum),
        .carry_i   (carry),
        .f_o       (f_q),
        .d1_o      (d1_q),
        .d2_o      (d2_q),
        .idx_o     (out_index_o),
        .ovf_o     (overflow_o)
    );

    assign out_value_o = f_q;
    assign out_diff_o  = d1_q;
endmodule

// File: rtl/diff_eval_chk.sv
`timescale 1ns/1ps
module diff_eval_chk #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          load_i,
    input logic          out_ready_i,
    input logic          out_valid_o,
    input logic [W-1:0]  out_value_o,
    input logic [IW-1:0] out_index_o,
    input logic          busy_o,
    input logic          overflow_o,
    input logic [W-1:0]  d2_q
);
    p_load_state_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (!out_valid_o && !overflow_o && !busy_o && out_index_o == '0));

    p_index_inc_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid_o) |-> (out_index_o == ($past(out_index_o) + IW'(1))));

    p_d2_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(d2_q));

    p_step_done_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_o) && !$past(load_i)) |-> out_valid_o);

    p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i && !load_i) |=>
            (out_valid_o && $stable(out_value_o) && $stable(out_index_o)));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !load_i) |=> overflow_o);
endmodule

bind diff_eval_top diff_eval_chk #(.W(W), .IW(IW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_value_o (out_value_o),
    .out_index_o (out_index_o),
    .busy_o      (busy_o),
    .overflow_o  (overflow_o),
    .d2_q        (d2_q)
);

// File: tb/sim_diff_eval_top.sv
`timescale 1ns/1ps
module sim_diff_eval_top;
    localparam int W  = 32;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst, load_i, step_i, out_ready_i;
    logic [W-1:0]  f_init_i, d1_init_i, d2_init_i;
    logic          out_valid_o, busy_o, overflow_o;
    logic [W-1:0]  out_value_o, out_diff_o;
    logic [IW-1:0] out_index_o;

    always #2.5 clk = ~clk;

    diff_eval_top #(.W(W), .IW(IW)) u0 (
        .clk(clk), .rst(rst), .load_i(load_i),
        .f_init_i(f_init_i), .d1_init_i(d1_init_i), .d2_init_i(d2_init_i),
        .step_i(step_i), .out_ready_i(out_ready_i),
        .out_valid_o(out_valid_o), .out_value_o(out_value_o),
        .out_diff_o(out_diff_o), .out_index_o(out_index_o),
        .busy_o(busy_o), .overflow_o(overflow_o)
    );

    typedef struct packed {
        logic [W-1:0]  f;
        logic [W-1:0]  d;
        logic [IW-1:0] n;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    logic [W-1:0]  m_f, m_d1, m_d2;
    logic [IW-1:0] m_n;
    logic          m_ovf;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: pops and compares each accepted result
    always @(negedge clk) begin
        if (!rst && out_valid_o && out_ready_i) begin
            if (q.size() == 0) begin
                chk(0, "R3 unexpected result", 64'(out_value_o), 64'(0));
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(out_value_o == e.f, "R3 value", 64'(out_value_o), 64'(e.f));
                chk(out_diff_o  == e.d, "R4 first difference", 64'(out_diff_o), 64'(e.d));
                chk(out_index_o == e.n, "R3 index", 64'(out_index_o), 64'(e.n));
            end
        end
    end

    task automatic model_step();
        logic [W:0] s1, s2;
        s1    = {1'b0, m_d1} + {1'b0, m_d2};
        m_d1  = s1[W-1:0];
        s2    = {1'b0, m_f} + {1'b0, m_d1};
        m_f   = s2[W-1:0];
        m_ovf = m_ovf | s1[W] | s2[W];
        m_n   = m_n + IW'(1);
        q.push_back('{f: m_f, d: m_d1, n: m_n});
    endtask

    task automatic do_load(input logic [W-1:0] f, input logic [W-1:0] d1,
                           input logic [W-1:0] d2);
        f_init_i = f; d1_init_i = d1; d2_init_i = d2;
        load_i = 1'b1;
        tick();
        load_i = 1'b0;
        m_f = f; m_d1 = d1; m_d2 = d2; m_n = '0; m_ovf = 1'b0;
        @(negedge clk);
        chk(out_value_o == f, "R2 loaded value", 64'(out_value_o), 64'(f));
        chk(out_diff_o == d1, "R2 loaded difference", 64'(out_diff_o), 64'(d1));
        chk(out_index_o == '0, "R2 index cleared", 64'(out_index_o), 64'(0));
        chk(!out_valid_o && !overflow_o, "R2 flags cleared",
            64'({out_valid_o, overflow_o}), 64'(0));
    endtask

    // Driver: predicts, pushes, then requests one step (ready assumed high)
    task automatic do_step();
        model_step();
        step_i = 1'b1;
        tick();
        step_i = 1'b0;
        @(negedge clk);
        chk(busy_o && !out_valid_o, "R5 first busy cycle",
            64'({busy_o, out_valid_o}), 64'(2));
        tick();
        @(negedge clk);
        chk(busy_o && !out_valid_o, "R5 second busy cycle",
            64'({busy_o, out_valid_o}), 64'(2));
        tick();
        @(negedge clk);
        chk(!busy_o && out_valid_o, "R5 result valid",
            64'({busy_o, out_valid_o}), 64'(1));
        chk(overflow_o == m_ovf, "R8 overflow flag", 64'(overflow_o), 64'(m_ovf));
        tick();
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; load_i = 1'b0; step_i = 1'b0; out_ready_i = 1'b1;
        f_init_i = '0; d1_init_i = '0; d2_init_i = '0;
        m_f = '0; m_d1 = '0; m_d2 = '0; m_n = '0; m_ovf = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!out_valid_o && !overflow_o && !busy_o, "R1 reset flags",
            64'({out_valid_o, overflow_o, busy_o}), 64'(0));
        chk(out_index_o == '0, "R1 reset index", 64'(out_index_o), 64'(0));

        // R3 R4: example sequence 43 47 53 61 with differences 2 4 6 8
        do_load(32'd41, 32'd0, 32'd2);
        for (int i = 0; i < 4; i++) do_step();
        chk(out_value_o == 32'd61, "R4 fourth value", 64'(out_value_o), 64'd61);
        chk(out_diff_o == 32'd8, "R4 fourth difference", 64'(out_diff_o), 64'd8);

        // R6: step held high during a step counts once
        model_step();
        step_i = 1'b1;
        tick();
        tick();
        step_i = 1'b0;
        tick();
        tick();
        tick();
        @(negedge clk);
        chk(!busy_o && !out_valid_o, "R6 extra request ignored",
            64'({busy_o, out_valid_o}), 64'(0));
        chk(out_index_o == 16'd5, "R6 single advance", 64'(out_index_o), 64'd5);

        // R7: stall holds the result and ignores new steps
        out_ready_i = 1'b0;
        model_step();
        step_i = 1'b1;
        tick();
        step_i = 1'b0;
        tick();
        tick();
        step_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(out_valid_o && !busy_o, "R7 held valid, step ignored",
                64'({out_valid_o, busy_o}), 64'(2));
            chk(out_value_o == m_f, "R7 held value", 64'(out_value_o), 64'(m_f));
            tick();
        end
        step_i = 1'b0;
        out_ready_i = 1'b1;
        tick();
        @(negedge clk);
        chk(!out_valid_o && !busy_o, "R7 taken once ready",
            64'({out_valid_o, busy_o}), 64'(0));
        chk(out_index_o == m_n, "R7 index unchanged by stalled step",
            64'(out_index_o), 64'(m_n));

        // R2: load aborts a running step; then another polynomial
        step_i = 1'b1;
        tick();
        step_i = 1'b0;
        f_init_i = 32'd5; d1_init_i = 32'd1; d2_init_i = 32'd4;
        load_i = 1'b1;
        tick();
        load_i = 1'b0;
        m_f = 32'd5; m_d1 = 32'd1; m_d2 = 32'd4; m_n = '0; m_ovf = 1'b0;
        @(negedge clk);
        chk(!busy_o && !out_valid_o, "R2 load aborts step",
            64'({busy_o, out_valid_o}), 64'(0));
        chk(out_value_o == 32'd5, "R2 abort value", 64'(out_value_o), 64'd5);
        tick();
        tick();
        @(negedge clk);
        chk(out_value_o == 32'd5 && !out_valid_o, "R2 no late result",
            64'(out_value_o), 64'd5);
        do_step();
        do_step();
        chk(out_value_o == 32'd19, "R3 second polynomial", 64'(out_value_o), 64'd19);

        // R8 R9: carry in the function phase, sticky, cleared by load
        do_load(32'hFFFF_FFF0, 32'd0, 32'd8);
        do_step();
        chk(!overflow_o, "R8 no carry yet", 64'(overflow_o), 64'(0));
        do_step();
        chk(overflow_o, "R8 carry from value", 64'(overflow_o), 64'(1));
        do_step();
        chk(overflow_o, "R9 overflow sticky", 64'(overflow_o), 64'(1));
        do_load(32'd41, 32'd0, 32'd2);
        chk(!overflow_o, "R9 cleared by load", 64'(overflow_o), 64'(0));

        // R8: carry in the difference phase
        do_load(32'd0, 32'hFFFF_FFFF, 32'd1);
        do_step();
        chk(overflow_o, "R8 carry from difference", 64'(overflow_o), 64'(1));

        tick();
        chk(q.size() == 0, "R3 all results seen", 64'(q.size()), 64'(0));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule